// File: doc/BRIEF.md
# Display Brightness and Blanking Control

This block sits at the end of the pixel path of a tile-based video generator. It holds one 8-bit control byte, loaded through a simple bus write port. The byte carries a force-blank flag and a 4-bit brightness level. Every incoming 15-bit RGB pixel passes through the block, and each colour channel is scaled by the same factor, which the brightness level sets.

Even at the lowest level the picture keeps one sixteenth of its intensity, so it never goes fully black. Setting force-blank turns the visible output black. The active-video, horizontal-blank and vertical-blank timing flags still pass through, so the renderer and frame timing keep running. The force-blank flag is also driven out as a status signal for neighbouring blocks, such as memory-access arbiters.

The block has one register stage. Pixels and timing flags leave it one clock after they arrive, still aligned with each other. A register write changes the pixels captured from the next clock edge onward.

Top module: `disp_bright_ctrl`

## Requirements
- R1: When `wr_en` is high at a clock edge, the register loads `wr_data`. Bit 7 is the force-blank flag and bits 3:0 are the brightness level L.
- R2: With force-blank clear and L = 15, `pix_out` equals the pixel input unchanged.
- R3: With force-blank clear and L = 0, each channel value c comes out as floor(c / 16). A channel at 31 therefore gives 1, not 0.
- R4: With force-blank clear, each channel comes out as floor(c × (L + 1) / 16), using the same factor for all three channels. The pixel layout is red in bits 4:0, green in bits 9:5 and blue in bits 14:10.
- R5: While force-blank is set, `pix_out` is all zeros, whatever the brightness level or pixel input.
- R6: Bits 6:4 of a written byte are ignored. `rd_data` always returns them as zero.
- R7: After reset, the register reads 0x80 (force-blank set, level 0), and `pix_out` and the delayed timing flags are zero.
- R8: `pix_out`, `act_out`, `hblank_out` and `vblank_out` follow their inputs with exactly one clock of delay. The timing flags are passed on whether or not force-blank is set.
- R9: A pixel captured at the same edge as a register write uses the old setting. The pixel captured at the next edge uses the new setting.
- R10: `blank_out` equals bit 7 of the stored register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Control byte to write |
| rd_data | output | 8 | Stored control byte, with reserved bits returned as zero |
| pix_in | input | 15 | Renderer pixel, {blue, green, red}, 5 bits each |
| act_in | input | 1 | Active-video flag for `pix_in` |
| hblank_in | input | 1 | Horizontal blanking flag |
| vblank_in | input | 1 | Vertical blanking flag |
| pix_out | output | 15 | Scaled or blanked pixel |
| act_out | output | 1 | Active-video flag, delayed to match `pix_out` |
| hblank_out | output | 1 | Horizontal blanking flag, delayed |
| vblank_out | output | 1 | Vertical blanking flag, delayed |
| blank_out | output | 1 | Force-blank status |

## Verification
The hardest case to reach from the ports is a write that lands on the very edge where a pixel is captured. The bench drives the write strobe and a new pixel in the same half-cycle, then checks two consecutive outputs. The first must still be blanked under the old byte. The second must show the new brightness. Channel values near the rounding boundaries are chosen so that a wrong multiplier, a missing +1 or a wrong shift changes at least one channel. The timing flags are toggled while force-blank is set, to show that they pass through unaffected.

// File: rtl/disp_bright_ctrl.sv
module disp_bright_ctrl #(
  parameter int CH_W  = 5,
  parameter int NCH   = 3,
  parameter int LVL_W = 4,
  parameter int REG_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_W-1:0]      wr_data,
  output logic [REG_W-1:0]      rd_data,
  input  logic [CH_W*NCH-1:0]   pix_in,
  input  logic                  act_in,
  input  logic                  hblank_in,
  input  logic                  vblank_in,
  output logic [CH_W*NCH-1:0]   pix_out,
  output logic                  act_out,
  output logic                  hblank_out,
  output logic                  vblank_out,
  output logic                  blank_out
);
  localparam int PIX_W  = CH_W * NCH;
  localparam int PROD_W = CH_W + LVL_W + 1;
  localparam int BLK    = REG_W - 1;

  logic             blank_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PIX_W-1:0] scaled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= 1'b1;
      lvl_q   <= '0;
    end else if (wr_en) begin
      blank_q <= wr_data[BLK];
      lvl_q   <= wr_data[LVL_W-1:0];
    end
  end

  always_comb begin
    rd_data              = '0;
    rd_data[BLK]         = blank_q;
    rd_data[LVL_W-1:0]   = lvl_q;
  end

  assign blank_out = blank_q;

  logic [LVL_W:0] factor;
  assign factor = {1'b0, lvl_q} + 1'b1;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [PROD_W-1:0] prod;
    assign prod = PROD_W'(pix_in[i*CH_W +: CH_W]) * PROD_W'(factor);
    assign scaled[i*CH_W +: CH_W] = prod[LVL_W +: CH_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_out    <= '0;
      act_out    <= 1'b0;
      hblank_out <= 1'b0;
      vblank_out <= 1'b0;
    end else begin
      pix_out    <= blank_q ? '0 : scaled;
      act_out    <= act_in;
      hblank_out <= hblank_in;
      vblank_out <= vblank_in;
    end
  end

  p_wr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[BLK] == $past(wr_data[BLK])) &&
              (rd_data[LVL_W-1:0] == $past(wr_data[LVL_W-1:0])));

  p_full_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[BLK] && rd_data[LVL_W-1:0] == {LVL_W{1'b1}}) |=> pix_out == $past(pix_in));

  p_floor_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[BLK] && pix_in[CH_W-1:0] == {CH_W{1'b1}}) |=> pix_out[CH_W-1:0] != '0);

  p_blank_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BLK] |=> pix_out == '0);

  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[BLK-1:LVL_W] == '0);

  p_timing_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (act_out == $past(act_in)) && (hblank_out == $past(hblank_in))
                     && (vblank_out == $past(vblank_in)));

  p_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    blank_out == rd_data[BLK]);
endmodule

// File: tb/disp_bright_ctrl_bench.sv
module disp_bright_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [14:0] pix_in = '0;
  logic        act_in = 1'b0, hblank_in = 1'b0, vblank_in = 1'b0;
  logic [14:0] pix_out;
  logic        act_out, hblank_out, vblank_out, blank_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  disp_bright_ctrl u_disp_bright_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pix_in(pix_in), .act_in(act_in), .hblank_in(hblank_in), .vblank_in(vblank_in),
    .pix_out(pix_out), .act_out(act_out), .hblank_out(hblank_out),
    .vblank_out(vblank_out), .blank_out(blank_out)
  );

  // {ctrl byte, input pixel, expected output pixel}
  localparam int NV = 8;
  localparam logic [37:0] VEC [NV] = '{
    {8'h0F, 15'h7FFF, 15'h7FFF},  // R2 full level
    {8'h07, 15'h7E01, 15'h3D00},  // R4 level 7: b31->15 g16->8 r1->0
    {8'h00, 15'h7FFF, 15'h0421},  // R3 floor keeps 1
    {8'h8F, 15'h7FFF, 15'h0000},  // R5 blank beats level
    {8'h7F, 15'h7FFF, 15'h7FFF},  // R6 bits 6:4 ignored
    {8'h03, 15'h2A9E, 15'h08A7},  // R4 level 3: 10,20,30 -> 2,5,7
    {8'h0A, 15'h4210, 15'h2D6B},  // R4 level 10: 16 -> 11
    {8'h00, 15'h3DEF, 15'h0000}   // R3 15 -> 0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset rd_data", 32'(rd_data), 32'h80);
    chk("R7 reset blank_out", 32'(blank_out), 32'h1);
    chk("R7 reset pix_out", 32'(pix_out), 32'h0);
    chk("R7 reset act_out", 32'(act_out), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    pix_in = 15'h7FFF;
    @(negedge clk);
    chk("R7 R5 blanked after reset", 32'(pix_out), 32'h0);

    for (int i = 0; i < NV; i++) begin
      write_ctrl(VEC[i][37:30]);
      pix_in = VEC[i][29:15];
      chk("R1 R6 readback", 32'(rd_data), 32'(VEC[i][37:30] & 8'h8F));
      chk("R10 blank_out", 32'(blank_out), 32'(VEC[i][37]));
      @(negedge clk);
      chk("R2 R3 R4 R5 pixel", 32'(pix_out), 32'(VEC[i][14:0]));
    end

    // R9: write and pixel at the same edge
    write_ctrl(8'h80);
    pix_in = 15'h7FFF;
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h0F;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 old setting on write edge", 32'(pix_out), 32'h0);
    @(negedge clk);
    chk("R9 new setting next edge", 32'(pix_out), 32'h7FFF);

    // R8: timing passes through while blanked, one cycle late
    write_ctrl(8'h8F);
    act_in = 1'b1; hblank_in = 1'b0; vblank_in = 1'b1;
    #1;
    chk("R8 act not early", 32'(act_out), 32'h0);
    @(negedge clk);
    chk("R8 act_out delayed", 32'(act_out), 32'h1);
    chk("R8 vblank_out delayed", 32'(vblank_out), 32'h1);
    chk("R8 hblank_out delayed", 32'(hblank_out), 32'h0);
    act_in = 1'b0; hblank_in = 1'b1; vblank_in = 1'b0;
    @(negedge clk);
    chk("R8 hblank_out under blank", 32'(hblank_out), 32'h1);
    chk("R8 act_out falls", 32'(act_out), 32'h0);
    chk("R5 pixel still black", 32'(pix_out), 32'h0);

    // R4: single channel, green only, level 1 -> floor(31*2/16)=3
    write_ctrl(8'h01);
    pix_in = 15'h03E0;
    @(negedge clk);
    chk("R4 green only level 1", 32'(pix_out), 32'h0060);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule